// File: doc/BRIEF.md
# Decimating Proportional-Integral Loop Filter for Clock Recovery

This block is the digital loop filter of a clock-and-data-recovery loop. A phase detector upstream delivers, once per unit interval, a ternary decision that says whether the sampling clock is early, late or gives no information. The filter groups a fixed number L of valid decisions into a window. At the close of each window it reduces them to one decimated value, in one of two ways. In sum mode it is the plain total of the window. In vote mode it is only the sign of that total.

The decimated value feeds two paths. The proportional path scales it by a power-of-two gain. The integral path scales it by a second power-of-two gain and adds it into a saturating frequency register. At every window close the phase code moves by the proportional term plus the updated frequency register. The phase code wraps around its width and drives a phase interpolator or a digitally controlled oscillator. The mode and the two gain shifts are static settings and are changed only while the block is held in reset.

Top module: `dcdr_loop_filter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the window count, the partial window total, the frequency register and phaseCode to zero. After reset a window of all-zero decisions leaves phaseCode at zero.
- R2: Decisions use 2-bit two's-complement encoding: 2'b01 is +1, 2'b11 is -1 and 2'b00 is 0. 2'b10 is never driven while decValid is high. A decision counts only at an edge where decValid is high, and the value on decValue at any other edge has no effect.
- R3: phaseCode changes only at the clock edge that samples the L-th valid decision of a window. At every other edge it holds its value.
- R4: With voteMode low, the decimated value is the signed total of the L decisions, in the range -L to +L.
- R5: With voteMode high, the decimated value is +1 when the window total is positive, 0 when it is zero and -1 when it is negative.
- R6: The proportional term is the decimated value shifted left by kpShift. The integral increment is the decimated value shifted left by kiShift.
- R7: The frequency register takes in one integral increment per window, at the window close. phaseCode then advances by the proportional term plus the frequency register value after that window's increment.
- R8: The frequency register, FREQ_W bits signed, saturates at its largest and smallest representable values and never wraps.
- R9: phaseCode arithmetic is modulo 2^PHASE_W. The low PHASE_W bits of the frequency register take part in the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per unit interval |
| rst | input | 1 | Synchronous reset, active high |
| decValid | input | 1 | Qualifies decValue as a detector decision |
| decValue | input | 2 | Ternary decision, two's complement (+1, 0, -1) |
| voteMode | input | 1 | 0: sum decimation, 1: sign-vote decimation |
| kpShift | input | SHIFT_W | Proportional gain as a left-shift count |
| kiShift | input | SHIFT_W | Integral gain as a left-shift count |
| phaseCode | output | PHASE_W | Phase-control code, wraps modulo 2^PHASE_W |

## Verification
The bench checks phaseCode after every fed cycle. A design that updates on the wrong edge, or that counts a decision while valid is low, moves the code one cycle early or late and is caught. In vote mode the bench uses windows whose totals are positive, zero and negative but larger than one in size, so a design that passed the raw total through would step by the wrong amount. The frequency register is driven to both rails with the largest integral gain. A register that wraps instead of saturating makes the phase increments change sign, and a design that adds the stale frequency value makes every step lag by one increment. A reset in the middle of operation must drop the stored frequency too, which a following all-zero window shows at phaseCode.

// File: rtl/cdr_lf_pkg.sv
package cdr_lf_pkg;

  // strobes from window control into the datapath
  typedef struct packed {
    logic accept;   // a valid decision is taken this cycle
    logic close;    // that decision is the last of its window
  } lfStrobes_t;

  // two's-complement decision codes
  localparam logic [1:0] DEC_PLUS  = 2'b01;
  localparam logic [1:0] DEC_MINUS = 2'b11;
  localparam logic [1:0] DEC_ZERO  = 2'b00;

endpackage

// File: rtl/cdr_lf_ctrl.sv
module cdr_lf_ctrl
  import cdr_lf_pkg::*;
#(
  parameter int DECIM_L = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       decValid,
  output lfStrobes_t stb
);

  localparam int CNT_W = $clog2(DECIM_L);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DECIM_L - 1);

  logic [CNT_W-1:0] winCount;
  logic             atLast;

  assign atLast = (winCount == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      winCount <= '0;
    end else if (decValid) begin
      if (atLast) winCount <= '0;
      else        winCount <= winCount + 1'b1;
    end
  end

  always_comb begin
    stb.accept = decValid;
    stb.close  = decValid && atLast;
  end

endmodule

// File: rtl/cdr_lf_datapath.sv
module cdr_lf_datapath
  import cdr_lf_pkg::*;
#(
  parameter int DECIM_L = 8,
  parameter int PHASE_W = 10,
  parameter int FREQ_W  = 16,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  lfStrobes_t         stb,
  input  logic [1:0]         decValue,
  input  logic               voteMode,
  input  logic [SHIFT_W-1:0] kpShift,
  input  logic [SHIFT_W-1:0] kiShift,
  output logic [PHASE_W-1:0] phaseCode,
  output logic [FREQ_W-1:0]  freqAcc
);

  // window total spans -L..+L
  localparam int SUM_W = $clog2(DECIM_L) + 2;
  // headroom for the unsaturated integral sum
  localparam int INC_W = FREQ_W + 2;
  localparam logic signed [INC_W-1:0] SAT_HI = {3'b000, {(FREQ_W-1){1'b1}}};
  localparam logic signed [INC_W-1:0] SAT_LO = {3'b111, {(FREQ_W-1){1'b0}}};

  logic signed [SUM_W-1:0] partialSum;
  logic signed [SUM_W-1:0] decSigned;
  logic signed [SUM_W-1:0] windowSum;
  logic signed [SUM_W-1:0] decimVal;

  // decision decode
  always_comb begin
    unique case (decValue)
      DEC_PLUS:  decSigned = SUM_W'(1);
      DEC_MINUS: decSigned = -SUM_W'(1);
      default:   decSigned = '0;
    endcase
  end

  assign windowSum = partialSum + decSigned;

  always_ff @(posedge clk) begin
    if (rst) begin
      partialSum <= '0;
    end else if (stb.accept) begin
      partialSum <= stb.close ? '0 : windowSum;
    end
  end

  // decimator: full total or its sign
  always_comb begin
    if (voteMode) begin
      if (windowSum > 0)      decimVal = SUM_W'(1);
      else if (windowSum < 0) decimVal = -SUM_W'(1);
      else                    decimVal = '0;
    end else begin
      decimVal = windowSum;
    end
  end

  // integral path with saturation
  logic signed [INC_W-1:0] incExt;
  logic signed [INC_W-1:0] incShifted;
  logic signed [INC_W-1:0] freqExt;
  logic signed [INC_W-1:0] freqRaw;
  logic        [FREQ_W-1:0] freqNext;

  always_comb begin
    incExt     = {{(INC_W-SUM_W){decimVal[SUM_W-1]}}, decimVal};
    incShifted = incExt <<< kiShift;
    freqExt    = {{2{freqAcc[FREQ_W-1]}}, freqAcc};
    freqRaw    = freqExt + incShifted;
    if (freqRaw > SAT_HI)      freqNext = SAT_HI[FREQ_W-1:0];
    else if (freqRaw < SAT_LO) freqNext = SAT_LO[FREQ_W-1:0];
    else                       freqNext = freqRaw[FREQ_W-1:0];
  end

  // proportional path and phase update
  logic signed [PHASE_W-1:0] propExt;
  logic        [PHASE_W-1:0] propShifted;
  logic        [PHASE_W-1:0] phaseNext;

  always_comb begin
    propExt     = {{(PHASE_W-SUM_W){decimVal[SUM_W-1]}}, decimVal};
    propShifted = propExt <<< kpShift;
    phaseNext   = phaseCode + propShifted + freqNext[PHASE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freqAcc   <= '0;
      phaseCode <= '0;
    end else if (stb.close) begin
      freqAcc   <= freqNext;
      phaseCode <= phaseNext;
    end
  end

endmodule

// File: rtl/dcdr_loop_filter.sv
module dcdr_loop_filter
  import cdr_lf_pkg::*;
#(
  parameter int DECIM_L = 8,
  parameter int PHASE_W = 10,
  parameter int FREQ_W  = 16,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               decValid,
  input  logic [1:0]         decValue,
  input  logic               voteMode,
  input  logic [SHIFT_W-1:0] kpShift,
  input  logic [SHIFT_W-1:0] kiShift,
  output logic [PHASE_W-1:0] phaseCode
);

  lfStrobes_t        stbs;
  logic [FREQ_W-1:0] freqAcc;

  cdr_lf_ctrl #(
    .DECIM_L(DECIM_L)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .decValid(decValid),
    .stb     (stbs)
  );

  cdr_lf_datapath #(
    .DECIM_L(DECIM_L),
    .PHASE_W(PHASE_W),
    .FREQ_W (FREQ_W),
    .SHIFT_W(SHIFT_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .stb      (stbs),
    .decValue (decValue),
    .voteMode (voteMode),
    .kpShift  (kpShift),
    .kiShift  (kiShift),
    .phaseCode(phaseCode),
    .freqAcc  (freqAcc)
  );

endmodule

// File: rtl/cdr_lf_checker.sv
module cdr_lf_checker #(
  parameter int PHASE_W = 10,
  parameter int FREQ_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               decValid,
  input logic [1:0]         decValue,
  input logic               stbClose,
  input logic [FREQ_W-1:0]  freqAcc,
  input logic [PHASE_W-1:0] phaseCode
);

  // R1: reset leaves the phase code at zero
  p_rst_clear_r1: assert property (@(posedge clk) rst |=> phaseCode == '0);

  // R2: the unused code is never presented as a valid decision
  p_dec_legal_r2: assert property (@(posedge clk) disable iff (rst)
    decValid |-> decValue != 2'b10);

  // R3: a window can only close on a valid decision
  p_close_valid_r3: assert property (@(posedge clk) disable iff (rst)
    stbClose |-> decValid);

  // R3: phase holds between window closes
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !stbClose |=> $stable(phaseCode));

  // R7: frequency register moves only at a window close
  p_freq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stbClose |=> $stable(freqAcc));

  // R8: no jump from the upper quarter of the range into the lower quarter
  p_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (freqAcc[FREQ_W-1:FREQ_W-2] == 2'b01) |=> (freqAcc[FREQ_W-1:FREQ_W-2] != 2'b10));

  p_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (freqAcc[FREQ_W-1:FREQ_W-2] == 2'b10) |=> (freqAcc[FREQ_W-1:FREQ_W-2] != 2'b01));

endmodule

bind dcdr_loop_filter cdr_lf_checker #(
  .PHASE_W(PHASE_W),
  .FREQ_W (FREQ_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .decValid (decValid),
  .decValue (decValue),
  .stbClose (stbs.close),
  .freqAcc  (freqAcc),
  .phaseCode(phaseCode)
);

// File: tb/dcdr_loop_filter_tb.sv
module dcdr_loop_filter_tb_top;

  localparam int L       = 8;
  localparam int PHASE_W = 10;
  localparam int FREQ_W  = 16;
  localparam int SHIFT_W = 3;
  localparam int PMASK   = (1 << PHASE_W) - 1;
  localparam int FMAX    = (1 << (FREQ_W - 1)) - 1;
  localparam int FMIN    = -(1 << (FREQ_W - 1));

  logic               clk = 1'b0;
  logic               rst;
  logic               decValid;
  logic [1:0]         decValue;
  logic               voteMode;
  logic [SHIFT_W-1:0] kpShift;
  logic [SHIFT_W-1:0] kiShift;
  logic [PHASE_W-1:0] phaseCode;

  always #5 clk = ~clk;

  dcdr_loop_filter #(
    .DECIM_L(L), .PHASE_W(PHASE_W), .FREQ_W(FREQ_W), .SHIFT_W(SHIFT_W)
  ) dut_i (
    .clk(clk), .rst(rst), .decValid(decValid), .decValue(decValue),
    .voteMode(voteMode), .kpShift(kpShift), .kiShift(kiShift),
    .phaseCode(phaseCode)
  );

  int total = 0;
  int bad   = 0;

  // reference state built from the requirements
  int mSum, mCnt, mFreq, mPhase;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: phaseCode=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mSum = 0; mCnt = 0; mFreq = 0; mPhase = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; decValid = 1'b0; decValue = 2'b00;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  // drive one cycle; d in {-1,0,1}; check the phase after the edge
  task automatic feed(input int d, input bit v, input string req);
    int dm;
    @(negedge clk);
    decValid = v;
    decValue = (d > 0) ? 2'b01 : (d < 0) ? 2'b11 : 2'b00;
    @(posedge clk);
    if (v) begin
      mSum += d;
      mCnt++;
      if (mCnt == L) begin
        if (voteMode) dm = (mSum > 0) ? 1 : (mSum < 0) ? -1 : 0;
        else          dm = mSum;
        mFreq += dm * (1 << kiShift);
        if (mFreq > FMAX) mFreq = FMAX;
        if (mFreq < FMIN) mFreq = FMIN;
        mPhase = (mPhase + dm * (1 << kpShift) + mFreq) & PMASK;
        mSum = 0;
        mCnt = 0;
      end
    end
    #1;
    check(req, int'(phaseCode), mPhase);
  endtask

  // window of nPlus +1, nMinus -1, rest zero
  task automatic window(input int nPlus, input int nMinus, input string req);
    for (int i = 0; i < L; i++) begin
      if (i < nPlus)               feed(1, 1'b1, req);
      else if (i < nPlus + nMinus) feed(-1, 1'b1, req);
      else                         feed(0, 1'b1, req);
    end
  endtask

  task automatic testReset();
    voteMode = 1'b0; kpShift = 3'd2; kiShift = 3'd1;
    doReset();
    #1 check("R1 reset value", int'(phaseCode), 0);
    window(0, 0, "R1 zero window after reset");
  endtask

  task automatic testSumMode();
    voteMode = 1'b0; kpShift = 3'd2; kiShift = 3'd0;
    doReset();
    window(5, 1, "R4 R6 R7 sum +4");
    window(0, 7, "R4 R6 R7 sum -7");
    window(8, 0, "R4 sum full +L");
    window(3, 3, "R4 sum zero total");
  endtask

  task automatic testValidGaps();
    voteMode = 1'b0; kpShift = 3'd1; kiShift = 3'd2;
    doReset();
    for (int i = 0; i < L; i++) begin
      feed(1, 1'b1, "R2 valid decision");
      feed(1, 1'b0, "R2 ignored while invalid");
      feed(-1, 1'b0, "R3 hold during gap");
    end
    window(2, 5, "R2 R3 gapless window");
  endtask

  task automatic testVoteMode();
    voteMode = 1'b1; kpShift = 3'd3; kiShift = 3'd1;
    doReset();
    window(5, 2, "R5 vote positive");
    window(3, 3, "R5 vote zero");
    window(1, 6, "R5 vote negative");
    window(8, 0, "R5 vote full");
  endtask

  task automatic testSaturation();
    voteMode = 1'b0; kpShift = 3'd0; kiShift = 3'd7;
    doReset();
    for (int w = 0; w < 40; w++) window(8, 0, "R8 R9 saturate high");
    for (int w = 0; w < 72; w++) window(0, 8, "R8 R9 saturate low");
    for (int w = 0; w < 4; w++)  window(8, 0, "R8 leave low rail");
  endtask

  task automatic testMidReset();
    voteMode = 1'b0; kpShift = 3'd1; kiShift = 3'd4;
    doReset();
    window(6, 0, "R7 build frequency");
    window(6, 0, "R7 build frequency");
    feed(1, 1'b1, "R3 partial window");
    feed(1, 1'b1, "R3 partial window");
    doReset();
    #1 check("R1 mid-run reset", int'(phaseCode), 0);
    window(0, 0, "R1 frequency cleared");
    window(1, 0, "R1 partial total cleared");
  endtask

  initial begin
    fork
      begin
        rst = 1'b1; decValid = 1'b0; decValue = 2'b00;
        voteMode = 1'b0; kpShift = '0; kiShift = '0;
        testReset();
        testSumMode();
        testValidGaps();
        testVoteMode();
        testSaturation();
        testMidReset();
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule